// File: doc/BRIEF.md
# Stream End-of-Transfer Length Monitor

This block sits in line on a valid/ready byte stream whose total length is not known in advance. Each beat goes straight through to the downstream consumer without change. The monitor watches the handshakes as they pass. It finds the end of a transfer from the last-beat flag and counts how many bytes were actually carried, using the byte-enable mask. One cycle after the final beat it emits a single-cycle completion pulse. With that pulse it presents the byte total and the tag that was sampled on the first beat of the transfer.

The byte-enable mask follows one rule. Every beat before the final one must have all enables set. The final beat may carry fewer bytes, and those bytes must be the low ones: the mask is a run of ones that starts at bit 0. Two sticky flags record breaks of this rule, one for non-final beats and one for the final beat. The data width is a parameter and may only be 8, 16, 32, 64, 128, 256 or 512 bits. The count width is also a parameter, and the count saturates at its largest value.

Back-pressure works like this. The upstream ready is the downstream ready, in the same cycle. The downstream valid is the upstream valid. A beat transfers only in a cycle where both are high. While the consumer holds ready low, the block holds off the producer. Cycles without a handshake leave the counting state unchanged.

Top module: `stream_len_monitor`

## Requirements
- R1: `m_valid`, `m_data`, `m_keep` and `m_last` equal `s_valid`, `s_data`, `s_keep` and `s_last` in the same cycle. `s_ready` equals `m_ready` in the same cycle.
- R2: A cycle where `s_valid` or `m_ready` is low changes no count, tag or flag, whatever values `s_keep`, `s_last` and `s_tag` hold.
- R3: Bit i of `s_keep` marks byte i of `s_data` as valid. The reported count is (beats − 1) × (DATA_W/8) plus the number of ones in `s_keep` on the final beat.
- R4: `done` is high for exactly the one cycle after each handshake with `s_last` high, and at no other time. `done_bytes` and `done_tag` update at that same moment and then hold.
- R5: A transfer of a single beat with `s_last` high reports only the number of ones in that beat's `s_keep`.
- R6: A handshake with `s_last` low and `s_keep` not all ones sets `err_mid_keep` from the next cycle. The flag stays set until reset.
- R7: A handshake with `s_last` high sets `err_last_keep` from the next cycle, when `s_keep` is zero or is not a run of ones starting at bit 0. The flag stays set until reset. The count still follows R3.
- R8: `done_tag` is the value of `s_tag` on the first handshake of the transfer. Values of `s_tag` on later beats are ignored.
- R9: The count saturates at 2^CNT_W − 1 and does not wrap. The next transfer starts again from zero.
- R10: After reset, `done`, `done_bytes`, `done_tag`, `err_mid_keep` and `err_last_keep` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Upstream beat valid |
| s_ready | output | 1 | Upstream ready, equal to m_ready |
| s_data | input | DATA_W | Upstream beat data |
| s_keep | input | DATA_W/8 | Upstream byte enables, bit i covers byte i |
| s_last | input | 1 | Upstream final-beat flag |
| s_tag | input | TAG_W | Transfer tag, sampled on the first beat |
| m_valid | output | 1 | Downstream beat valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | DATA_W | Downstream beat data |
| m_keep | output | DATA_W/8 | Downstream byte enables |
| m_last | output | 1 | Downstream final-beat flag |
| done | output | 1 | One-cycle completion pulse |
| done_bytes | output | CNT_W | Byte total of the last completed transfer |
| done_tag | output | TAG_W | Tag of the last completed transfer |
| err_mid_keep | output | 1 | Sticky: partial enables on a non-final beat |
| err_last_keep | output | 1 | Sticky: zero or non-contiguous enables on a final beat |

## Verification
The running total and the first-beat marker cannot be seen until a transfer ends. A wrong value there shows up only at the next `done` pulse, as a wrong `done_bytes` or `done_tag`. That can be many beats after the fault. The bench therefore compares every registered output on every cycle, and it uses transfers of one beat, a few beats, and enough beats to saturate. A stall that is wrongly counted, or a wrong update of the first-beat marker, shows one cycle after the transfer ends. A sticky flag that is set or cleared wrongly shows in the cycle after the offending handshake.

// File: rtl/slm_pkg.sv
package slm_pkg;

  localparam int KEEP_MAX = 64;

  function automatic bit width_ok(input int w);
    return (w == 8) || (w == 16) || (w == 32) || (w == 64) ||
           (w == 128) || (w == 256) || (w == 512);
  endfunction

  function automatic int unsigned ones64(input logic [KEEP_MAX-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < KEEP_MAX; i++) begin
      n += {31'd0, v[i]};
    end
    return n;
  endfunction

endpackage

// File: rtl/slm_keep_check.sv
module slm_keep_check #(
  parameter int KEEP_W = 4,
  parameter int OW     = 3
) (
  input  logic [KEEP_W-1:0] keep,
  output logic              full,
  output logic              low_run,
  output logic [OW-1:0]     ones
);
  logic [KEEP_W-1:0] keep_inc;
  int unsigned       cnt;

  always_comb begin
    keep_inc = keep + 1'b1;
    full     = &keep;
    low_run  = (keep != '0) && ((keep & keep_inc) == '0);
    cnt      = slm_pkg::ones64(slm_pkg::KEEP_MAX'(keep));
    ones     = OW'(cnt);
  end
endmodule

// File: rtl/slm_byte_acc.sv
module slm_byte_acc #(
  parameter int CNT_W  = 32,
  parameter int KEEP_W = 4,
  parameter int OW     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             last,
  input  logic [OW-1:0]    ones,
  output logic             fin,
  output logic [CNT_W-1:0] total
);
  localparam logic [CNT_W:0] MAXV = {1'b0, {CNT_W{1'b1}}};
  localparam logic [CNT_W:0] BPB  = (CNT_W+1)'(KEEP_W);

  logic [CNT_W-1:0] run_q;
  logic [CNT_W:0]   add_amt;
  logic [CNT_W:0]   sum_w;
  logic [CNT_W-1:0] sat_w;

  always_comb begin
    add_amt = last ? (CNT_W+1)'(ones) : BPB;
    sum_w   = {1'b0, run_q} + add_amt;
    sat_w   = (sum_w > MAXV) ? MAXV[CNT_W-1:0] : sum_w[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
      fin   <= 1'b0;
      total <= '0;
    end else begin
      fin <= beat && last;
      if (beat) begin
        if (last) begin
          total <= sat_w;
          run_q <= '0;
        end else begin
          run_q <= sat_w;
        end
      end
    end
  end
endmodule

// File: rtl/slm_tag_err.sv
module slm_tag_err #(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             last,
  input  logic             full,
  input  logic             low_run,
  input  logic [TAG_W-1:0] tag_in,
  output logic [TAG_W-1:0] tag_out,
  output logic             err_mid,
  output logic             err_last
);
  logic             in_xfer;
  logic [TAG_W-1:0] tag_run;
  logic [TAG_W-1:0] tag_cur;

  always_comb tag_cur = in_xfer ? tag_run : tag_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_xfer  <= 1'b0;
      tag_run  <= '0;
      tag_out  <= '0;
      err_mid  <= 1'b0;
      err_last <= 1'b0;
    end else if (beat) begin
      if (last) begin
        in_xfer <= 1'b0;
        tag_out <= tag_cur;
        if (!low_run) err_last <= 1'b1;
      end else begin
        in_xfer <= 1'b1;
        tag_run <= tag_cur;
        if (!full) err_mid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/stream_len_monitor.sv
module stream_len_monitor #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 32,
  parameter int TAG_W  = 8,
  localparam int KEEP_W = DATA_W / 8,
  localparam int OW     = $clog2(KEEP_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic [KEEP_W-1:0] s_keep,
  input  logic              s_last,
  input  logic [TAG_W-1:0]  s_tag,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic [KEEP_W-1:0] m_keep,
  output logic              m_last,
  output logic              done,
  output logic [CNT_W-1:0]  done_bytes,
  output logic [TAG_W-1:0]  done_tag,
  output logic              err_mid_keep,
  output logic              err_last_keep
);
  generate
    if (!slm_pkg::width_ok(DATA_W)) begin : g_bad_width
      $error("stream_len_monitor: DATA_W must be 8,16,32,64,128,256 or 512");
    end
    if (CNT_W < OW) begin : g_bad_cnt
      $error("stream_len_monitor: CNT_W too narrow for one beat");
    end
  endgenerate

  logic          beat;
  logic          k_full;
  logic          k_run;
  logic [OW-1:0] k_ones;

  always_comb begin
    m_valid = s_valid;
    m_data  = s_data;
    m_keep  = s_keep;
    m_last  = s_last;
    s_ready = m_ready;
    beat    = s_valid && m_ready;
  end

  slm_keep_check #(.KEEP_W(KEEP_W), .OW(OW)) u_keep (
    .keep    (s_keep),
    .full    (k_full),
    .low_run (k_run),
    .ones    (k_ones)
  );

  slm_byte_acc #(.CNT_W(CNT_W), .KEEP_W(KEEP_W), .OW(OW)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .beat  (beat),
    .last  (s_last),
    .ones  (k_ones),
    .fin   (done),
    .total (done_bytes)
  );

  slm_tag_err #(.TAG_W(TAG_W)) u_tag (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat     (beat),
    .last     (s_last),
    .full     (k_full),
    .low_run  (k_run),
    .tag_in   (s_tag),
    .tag_out  (done_tag),
    .err_mid  (err_mid_keep),
    .err_last (err_last_keep)
  );
endmodule

// File: rtl/slm_checker.sv
module slm_checker #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 32,
  parameter int TAG_W  = 8,
  localparam int KEEP_W = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic [DATA_W-1:0] s_data,
  input logic [KEEP_W-1:0] s_keep,
  input logic              s_last,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              done,
  input logic [CNT_W-1:0]  done_bytes,
  input logic              err_mid_keep,
  input logic              err_last_keep
);
  AST_PASS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid == s_valid) && (s_ready == m_ready) && (m_data == s_data)); // R1
  AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && s_last) |=> done); // R4
  AST_DONE_ONLY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(s_valid && s_ready && s_last)); // R4
  AST_IDLE_HOLDS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && s_ready) |=> $stable(done_bytes)); // R2
  AST_MID_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !s_last && (s_keep != {KEEP_W{1'b1}})) |=> err_mid_keep); // R6
  AST_MID_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_mid_keep |=> err_mid_keep); // R6
  AST_LAST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && s_last && (s_keep == '0)) |=> err_last_keep); // R7
  AST_LAST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_last_keep |=> err_last_keep); // R7
  AST_GOOD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err_last_keep) |-> (done_bytes != '0)); // R5
endmodule

bind stream_len_monitor slm_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W), .TAG_W(TAG_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .s_valid       (s_valid),
  .s_ready       (s_ready),
  .s_data        (s_data),
  .s_keep        (s_keep),
  .s_last        (s_last),
  .m_valid       (m_valid),
  .m_ready       (m_ready),
  .m_data        (m_data),
  .done          (done),
  .done_bytes    (done_bytes),
  .err_mid_keep  (err_mid_keep),
  .err_last_keep (err_last_keep)
);

// File: tb/stream_len_monitor_test.sv
module stream_len_monitor_test;
  localparam int DW   = 32;
  localparam int KW   = DW / 8;
  localparam int CW   = 8;
  localparam int TW   = 4;
  localparam int MAXC = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [DW-1:0] s_data = '0;
  logic [KW-1:0] s_keep = '0;
  logic          s_last = 1'b0;
  logic [TW-1:0] s_tag = '0;
  logic          m_valid;
  logic          m_ready = 1'b0;
  logic [DW-1:0] m_data;
  logic [KW-1:0] m_keep;
  logic          m_last;
  logic          done;
  logic [CW-1:0] done_bytes;
  logic [TW-1:0] done_tag;
  logic          err_mid_keep;
  logic          err_last_keep;

  stream_len_monitor #(.DATA_W(DW), .CNT_W(CW), .TAG_W(TW)) uut (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_keep(s_keep),
    .s_last(s_last), .s_tag(s_tag),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_keep(m_keep),
    .m_last(m_last),
    .done(done), .done_bytes(done_bytes), .done_tag(done_tag),
    .err_mid_keep(err_mid_keep), .err_last_keep(err_last_keep)
  );

  always #5 clk = ~clk;

  int    n_vec = 0;
  int    n_bad = 0;
  int    cycles = 0;
  string cur_req = "R3";

  // behavioural reference state
  int unsigned   acc = 0;
  bit            in_x = 0;
  logic [TW-1:0] tag_first = '0;
  bit            e_done = 0;
  int unsigned   e_bytes = 0;
  logic [TW-1:0] e_tag = '0;
  bit            e_em = 0;
  bit            e_el = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int unsigned count_keep(input logic [KW-1:0] k);
    int unsigned n = 0;
    for (int i = 0; i < KW; i++) if (k[i]) n++;
    return n;
  endfunction

  function automatic bit keep_ok(input logic [KW-1:0] k);
    bit seen_zero = 0;
    if (!k[0]) return 0;
    for (int i = 0; i < KW; i++) begin
      if (!k[i]) seen_zero = 1;
      else if (seen_zero) return 0;
    end
    return 1;
  endfunction

  task automatic model_edge();
    e_done = 0;
    if (!rst_n) begin
      acc = 0; in_x = 0; tag_first = '0; e_bytes = 0; e_tag = '0; e_em = 0; e_el = 0;
    end else if (s_valid && m_ready) begin
      if (!in_x) tag_first = s_tag;
      if (s_last) begin
        e_bytes = acc + count_keep(s_keep);
        if (e_bytes > MAXC) e_bytes = MAXC;
        e_tag = tag_first;
        e_done = 1;
        if (!keep_ok(s_keep)) e_el = 1;
        acc = 0;
        in_x = 0;
      end else begin
        acc = acc + KW;
        if (acc > MAXC) acc = MAXC;
        in_x = 1;
        if (s_keep != {KW{1'b1}}) e_em = 1;
      end
    end
  endtask

  task automatic check_pass();
    chk("R1", {63'd0, m_valid}, {63'd0, s_valid});
    chk("R1", {63'd0, s_ready}, {63'd0, m_ready});
    chk("R1", 64'(m_data), 64'(s_data));
    chk("R1", 64'(m_keep), 64'(s_keep));
    chk("R1", {63'd0, m_last}, {63'd0, s_last});
  endtask

  task automatic check_regs();
    chk("R4", {63'd0, done}, {63'd0, e_done});
    chk(cur_req, 64'(done_bytes), 64'(e_bytes));
    chk("R8", 64'(done_tag), 64'(e_tag));
    chk("R6", {63'd0, err_mid_keep}, {63'd0, e_em});
    chk("R7", {63'd0, err_last_keep}, {63'd0, e_el});
  endtask

  task automatic step();
    #1;
    check_pass();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_regs();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; s_valid = 1'b0; m_ready = 1'b0;
    repeat (2) @(posedge clk);
    model_edge();
    @(negedge clk);
    rst_n = 1'b1;
    chk("R10", {63'd0, done}, 64'd0);
    chk("R10", 64'(done_bytes), 64'd0);
    chk("R10", 64'(done_tag), 64'd0);
    chk("R10", {62'd0, err_mid_keep, err_last_keep}, 64'd0);
  endtask

  task automatic send(input logic [KW-1:0] k, input bit last, input logic [TW-1:0] tag, input bit stall);
    bit hs;
    s_valid = 1'b1; s_data = $urandom; s_keep = k; s_last = last; s_tag = tag;
    do begin
      m_ready = stall ? (($urandom % 3) != 0) : 1'b1;
      hs = m_ready;
      step();
    end while (!hs);
    s_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b0; s_last = 1'b1; s_keep = 4'h5; s_tag = TW'($urandom);
      m_ready = (($urandom % 2) != 0);
      step();
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_bad++;
        $display("FAIL R4 watchdog actual=%0d expected<=100000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    do_reset();

    // R5: single-beat transfers
    cur_req = "R5";
    send(4'h1, 1, 4'h3, 0);
    idle(1);
    send(4'hF, 1, 4'h6, 0);
    // R4: back-to-back single-beat transfers give consecutive pulses
    send(4'h3, 1, 4'h9, 0);
    send(4'h7, 1, 4'hA, 0);
    idle(2);

    // R3 / R8: three beats, tag changes after first beat
    cur_req = "R3";
    send(4'hF, 0, 4'h5, 0);
    send(4'hF, 0, 4'hC, 0);
    send(4'h7, 1, 4'hE, 0);
    idle(1);

    // R2: random stalls and idle cycles with junk last/keep/tag
    cur_req = "R2";
    for (int t = 0; t < 6; t++) begin
      for (int b = 0; b < t; b++) send(4'hF, 0, TW'(t), 1);
      send(KW'((1 << ((t % KW) + 1)) - 1), 1, 4'h1, 1);
      idle(3);
    end

    // R9: saturation then fresh count
    cur_req = "R9";
    for (int b = 0; b < 69; b++) send(4'hF, 0, 4'h2, 0);
    send(4'hF, 1, 4'h4, 0);
    send(4'hF, 0, 4'h8, 0);
    send(4'h3, 1, 4'h0, 1);
    idle(2);

    // R7: non-contiguous and zero final enables
    cur_req = "R7";
    send(4'hF, 0, 4'hB, 0);
    send(4'h5, 1, 4'hB, 0);
    idle(2);
    send(4'h0, 1, 4'hD, 0);
    idle(2);

    // R6: partial enables on a non-final beat
    do_reset();
    cur_req = "R6";
    send(4'h3, 0, 4'h7, 0);
    send(4'hF, 1, 4'h1, 0);
    idle(2);
    send(4'hF, 1, 4'h2, 1);
    idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule